// File: doc/BRIEF.md
# Fence Instruction Decode Classifier

This block takes one candidate instruction as a stream of bytes and decides whether it is one of the three memory-fence encodings of the two-byte escape group. The encodings are load fence, store fence and full fence. Bytes arrive on a valid-qualified byte port. A start strobe marks the first byte of each instruction. A mode flag says whether 64-bit decoding rules apply, and a length limit input caps how many bytes one instruction may use.

While it walks the prefixes, the block tracks a small amount of state. Segment overrides and the address-size prefix pass through without effect. The operand-size, LOCK and both repeat prefixes poison a fence encoding. A REX byte is ignored, but only in 64-bit mode. After that comes the escape byte, the group byte and the ModRM byte. The block then reports a one-cycle done pulse carrying a one-hot class and the number of bytes consumed. When a byte ends the instruction early, the verdict arrives right after that byte.

Top module: `fence_decode`

## Requirements
- R1: During and after reset, with no instruction in progress, `done` is 0, `res` is 0 and `len` is 0.
- R2: The sequence 0x0F, 0xAE, then a ModRM byte with mod=11 (bits 7:6) classifies by the reg field (bits 5:3). The classes are reg=5 load fence, reg=6 full fence and reg=7 store fence, so ModRM 0xE8–0xEF, 0xF0–0xF7 and 0xF8–0xFF. The RM field (bits 2:0) never changes the result. The `res` encoding is bit0 load, bit1 store, bit2 full, bit3 invalid opcode and bit4 not in group.
- R3: Any number of the prefixes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65 and 0x67 before the escape byte leave the fence classification unchanged.
- R4: If any of 0x66, 0xF0, 0xF2 or 0xF3 precedes a fence encoding, the result is invalid opcode.
- R5: With `mode64`=1, a byte 0x40–0x4F before the escape byte is ignored, whether or not segment or address-size prefixes come before it.
- R6: With `mode64`=0, a byte 0x40–0x4F in the prefix position ends the instruction at once with not in group.
- R7: `len` equals the count of every byte consumed for the instruction, up to and including the byte that produced the verdict.
- R8: If the instruction reaches a byte that would make its length exceed `max_len`, that byte ends it with invalid opcode and `len` = `max_len`+1. A ModRM byte at exactly `max_len` is still classified normally.
- R9: The result is not in group in any of these cases: a first non-prefix byte other than 0x0F, a second opcode byte other than 0xAE, a ModRM with mod≠11, or a reg field below 5.
- R10: `done` rises in the cycle after the verdict byte is accepted and lasts exactly one cycle. While no instruction is open, a valid byte without `in_start` is ignored. A byte with `in_start` always begins a new instruction, abandoning any open one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_start | input | 1 | This byte is the first of a new instruction |
| in_byte | input | 8 | Instruction byte |
| mode64 | input | 1 | Apply 64-bit decode rules (REX accepted) |
| max_len | input | LEN_W | Longest permitted instruction, must be below 2**LEN_W-1 |
| done | output | 1 | One-cycle verdict strobe |
| res | output | 5 | One-hot class: load, store, full, invalid, not in group |
| len | output | LEN_W | Bytes consumed by the instruction |

## Verification
A bad phase state shows on the very next done pulse. If an escape byte is missed, a valid fence is reported as not in group. If the group byte is skipped, the verdict arrives one byte early with a short `len`. A poison flag that is stuck or lost flips fence results to or from invalid opcode in the same cycle the ModRM verdict appears. A wrong byte counter shows either as a `len` mismatch or as an overflow verdict at the wrong byte, so each check is made at the done pulse that follows the final byte.

// File: rtl/fence_decode.sv
module fence_decode #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [7:0]       in_byte,
  input  logic             mode64,
  input  logic [LEN_W-1:0] max_len,
  output logic             done,
  output logic [4:0]       res,
  output logic [LEN_W-1:0] len
);
  localparam logic [4:0] C_LOAD  = 5'b00001;
  localparam logic [4:0] C_STORE = 5'b00010;
  localparam logic [4:0] C_FULL  = 5'b00100;
  localparam logic [4:0] C_INV   = 5'b01000;
  localparam logic [4:0] C_NG    = 5'b10000;

  typedef enum logic [1:0] {PH_IDLE, PH_PFX, PH_OP2, PH_MRM} phase_t;

  phase_t           ph, ph_base, ph_nxt;
  logic [LEN_W-1:0] cnt, cnt_base;
  logic [LEN_W:0]   cnt_nxt;
  logic             poison, poison_base, poison_nxt;
  logic             take, fin;
  logic [4:0]       verdict;

  assign take        = in_valid && (in_start || ph != PH_IDLE);
  assign ph_base     = in_start ? PH_PFX : ph;
  assign cnt_base    = in_start ? '0 : cnt;
  assign poison_base = in_start ? 1'b0 : poison;
  assign cnt_nxt     = {1'b0, cnt_base} + 1'b1;

  wire is_seg   = (in_byte == 8'h26) || (in_byte == 8'h2E) || (in_byte == 8'h36) ||
                  (in_byte == 8'h3E) || (in_byte == 8'h64) || (in_byte == 8'h65) ||
                  (in_byte == 8'h67);
  wire is_bad   = (in_byte == 8'h66) || (in_byte == 8'hF0) ||
                  (in_byte == 8'hF2) || (in_byte == 8'hF3);
  wire is_rex   = (in_byte[7:4] == 4'h4);
  wire [1:0] md = in_byte[7:6];
  wire [2:0] rg = in_byte[5:3];

  always_comb begin
    fin        = 1'b0;
    verdict    = '0;
    ph_nxt     = ph_base;
    poison_nxt = poison_base;
    if (cnt_nxt > {1'b0, max_len}) begin
      fin     = 1'b1;
      verdict = C_INV;
    end else begin
      unique case (ph_base)
        PH_PFX: begin
          if (is_seg) begin
            ph_nxt = PH_PFX;
          end else if (is_bad) begin
            poison_nxt = 1'b1;
          end else if (is_rex && mode64) begin
            ph_nxt = PH_PFX;
          end else if (in_byte == 8'h0F) begin
            ph_nxt = PH_OP2;
          end else begin
            fin     = 1'b1;
            verdict = C_NG;
          end
        end
        PH_OP2: begin
          if (in_byte == 8'hAE) begin
            ph_nxt = PH_MRM;
          end else begin
            fin     = 1'b1;
            verdict = C_NG;
          end
        end
        PH_MRM: begin
          fin = 1'b1;
          if (md != 2'b11 || rg < 3'd5) verdict = C_NG;
          else if (poison_base)          verdict = C_INV;
          else if (rg == 3'd5)           verdict = C_LOAD;
          else if (rg == 3'd6)           verdict = C_FULL;
          else                           verdict = C_STORE;
        end
        default: begin
          fin     = 1'b1;
          verdict = C_NG;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      poison <= 1'b0;
      done   <= 1'b0;
      res    <= '0;
      len    <= '0;
    end else begin
      done <= 1'b0;
      res  <= '0;
      len  <= '0;
      if (take) begin
        cnt    <= cnt_nxt[LEN_W-1:0];
        poison <= poison_nxt;
        if (fin) begin
          ph   <= PH_IDLE;
          done <= 1'b1;
          res  <= verdict;
          len  <= cnt_nxt[LEN_W-1:0];
        end else begin
          ph <= ph_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/fence_decode_chk.sv
module fence_decode_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_start,
  input logic             mode64,
  input logic [LEN_W-1:0] max_len,
  input logic             done,
  input logic [4:0]       res,
  input logic [LEN_W-1:0] len
);
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (res == '0 && len == '0));
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(res) == 1);
  a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> len != '0);
  a_r10_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid));
  a_r2_fence_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res[0] || res[1] || res[2])) |-> len >= 3);
endmodule

bind fence_decode fence_decode_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
  .mode64(mode64), .max_len(max_len), .done(done), .res(res), .len(len));

// File: tb/sim_fence_decode.sv
module sim_fence_decode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_start = 1'b0, mode64 = 1'b0;
  logic [7:0] in_byte = '0;
  logic [4:0] max_len = 5'd15;
  logic       done;
  logic [4:0] res;
  logic [4:0] len;
  int total = 0, bad = 0;

  localparam logic [4:0] LD = 5'd1, ST = 5'd2, FU = 5'd4, IV = 5'd8, NG = 5'd16;

  always #10 clk = ~clk;

  fence_decode #(.LEN_W(5)) u0 (.*);

  typedef struct packed {
    logic [47:0] b;
    logic [3:0]  n;
    logic        m64;
    logic [4:0]  r;
    logic [4:0]  l;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{48'h00_00_00_E8_AE_0F, 4'd3, 1'b0, LD, 5'd3},
    '{48'h00_00_00_F0_AE_0F, 4'd3, 1'b0, FU, 5'd3},
    '{48'h00_00_00_F8_AE_0F, 4'd3, 1'b0, ST, 5'd3},
    '{48'h00_00_00_EF_AE_0F, 4'd3, 1'b0, LD, 5'd3},
    '{48'h00_00_F3_AE_0F_2E, 4'd4, 1'b0, FU, 5'd4},
    '{48'h00_00_FF_AE_0F_67, 4'd4, 1'b0, ST, 5'd4},
    '{48'h00_EA_AE_0F_3E_65, 4'd5, 1'b0, LD, 5'd5},
    '{48'h00_00_E8_AE_0F_66, 4'd4, 1'b0, IV, 5'd4},
    '{48'h00_00_F0_AE_0F_F0, 4'd4, 1'b0, IV, 5'd4},
    '{48'h00_00_F8_AE_0F_F2, 4'd4, 1'b0, IV, 5'd4},
    '{48'h00_00_E9_AE_0F_F3, 4'd4, 1'b0, IV, 5'd4},
    '{48'h00_00_E8_AE_0F_48, 4'd4, 1'b1, LD, 5'd4},
    '{48'h00_F5_AE_0F_4F_64, 4'd5, 1'b1, FU, 5'd5},
    '{48'h00_FA_AE_0F_40_67, 4'd5, 1'b1, ST, 5'd5},
    '{48'h00_00_00_00_00_48, 4'd1, 1'b0, NG, 5'd1},
    '{48'h00_00_00_E0_AE_0F, 4'd3, 1'b0, NG, 5'd3},
    '{48'h00_00_00_28_AE_0F, 4'd3, 1'b0, NG, 5'd3},
    '{48'h00_00_00_00_AF_0F, 4'd2, 1'b0, NG, 5'd2},
    '{48'h00_00_00_00_00_90, 4'd1, 1'b0, NG, 5'd1},
    '{48'h00_F0_AE_0F_48_66, 4'd5, 1'b1, IV, 5'd5}
  };

  task automatic put(input logic [7:0] b, input logic s);
    @(negedge clk);
    in_valid = 1'b1; in_start = s; in_byte = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic check(input string req, input logic [4:0] er, input logic [4:0] el);
    total++;
    if (!(done === 1'b1 && res === er && len === el)) begin
      bad++;
      $display("FAIL %s: done=%b res=%b len=%0d expected done=1 res=%b len=%0d",
               req, done, res, len, er, el);
    end
  endtask

  task automatic check_quiet(input string req);
    total++;
    if (!(done === 1'b0 && res === 5'd0 && len === 5'd0)) begin
      bad++;
      $display("FAIL %s: done=%b res=%b len=%0d expected done=0 res=0 len=0",
               req, done, res, len);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after reset");

    // R2 R3 R4 R5 R6 R7 R9 table walk
    for (int i = 0; i < NV; i++) begin
      mode64 = TBL[i].m64;
      for (int k = 0; k < int'(TBL[i].n); k++)
        put(TBL[i].b[8*k +: 8], k == 0);
      idle();
      check($sformatf("R2-table vec %0d", i), TBL[i].r, TBL[i].l);
      @(negedge clk);
      check_quiet($sformatf("R10 single pulse vec %0d", i));
    end

    // R8 overflow at max_len+1
    mode64 = 1'b0; max_len = 5'd4;
    put(8'h26, 1'b1); put(8'h26, 1'b0); put(8'h26, 1'b0); put(8'h26, 1'b0);
    put(8'h26, 1'b0); idle();
    check("R8 overflow", IV, 5'd5);

    // R8 ModRM exactly at limit
    max_len = 5'd5;
    put(8'h26, 1'b1); put(8'h2E, 1'b0); put(8'h0F, 1'b0); put(8'hAE, 1'b0);
    put(8'hE8, 1'b0); idle();
    check("R8 at limit", LD, 5'd5);
    max_len = 5'd15;

    // R10 byte without start while idle is ignored
    put(8'h0F, 1'b0); put(8'hAE, 1'b0); put(8'hE8, 1'b0); idle();
    check_quiet("R10 no start ignored");
    put(8'h90, 1'b1); idle();
    check("R10 fresh after ignored", NG, 5'd1);

    // R10 start abandons open instruction
    put(8'h66, 1'b1); put(8'h0F, 1'b0);
    put(8'h0F, 1'b1); put(8'hAE, 1'b0); put(8'hF0, 1'b0); idle();
    check("R10 restart", FU, 5'd3);

    // R7 long prefix run under default limit
    put(8'h26, 1'b1);
    for (int k = 0; k < 9; k++) put(8'h67, 1'b0);
    put(8'h0F, 1'b0); put(8'hAE, 1'b0); put(8'hFB, 1'b0); idle();
    check("R7 long length", ST, 5'd13);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule